// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical page frame. It is started on a translation-cache miss. It reads a directory entry from memory, and then a table entry. On the way it sets the accessed and dirty status bits in memory, and it checks the access rights. At the end it reports either the 20-bit frame number with its attributes, or a page fault. On a fault it keeps the faulting linear address.

The directory base is held in a register inside the block. A write forces the low 12 bits of that register to zero. The walker reaches memory through one request/response port. A request stays asserted, with a stable address and stable write data, until the memory returns a one-cycle acknowledge. A read returns its data together with the acknowledge. The result comes back as a one-cycle done pulse. A new walk is accepted only while the walker is idle.

Top module: `pgw_top`

## Requirements
- R1: After reset the outputs are as follows: `done_o`=0, `fault_o`=0, `mem_req_o`=0, `req_ready_o`=1 and `fault_addr_o`=0.
- R2: The first memory access of a walk is a read at the directory base plus four times linear bits 31:22. Bits 11:0 of the written base are forced to zero, and a base write takes effect from the next accepted walk onward.
- R3: The second read is at the entry's bits 31:12 shifted left by 12, plus four times linear bits 21:12.
- R4: A successful walk returns `frame_o` equal to table-entry bits 31:12, so that the physical address is `{frame_o, lin[11:0]}`. It also returns `attr_o` = {dirty bit of the updated table entry, AND of both U/S bits, AND of both R/W bits}.
- R5: A directory entry with bit 0 (present) clear ends the walk with a fault. There is no table read and no write.
- R6: A table entry with bit 0 clear ends the walk with a fault. The table entry is not written.
- R7: A present directory entry whose bit 5 (accessed) is clear is written back with bit 5 set before the table read. Bit 6 of a directory entry is never changed, and no write happens when bit 5 is already set.
- R8: A valid table entry is written back with bit 5 set, and also with bit 6 (dirty) set when the access is a write. The write happens only when the value changes, and it never alters any other bit.
- R9: A user access faults unless bit 2 (U/S) is set in both entries. A user write also faults unless bit 1 (R/W) is set in both entries. Supervisor accesses are not restricted. A protection fault leaves the table entry unwritten.
- R10: Every fault loads `fault_addr_o` with the walk's linear address. A successful walk leaves it unchanged.
- R11: `done_o` is a one-cycle pulse that comes after all write-backs. `req_ready_o` is high only while idle, and `req_valid_i` is ignored while a walk is in progress.
- R12: With base 0x00010000 and linear 0x0301008A, the walk reads 0x00010030. A table base of 0x05001 then gives a read at 0x05001040, and a frame of 0x03000 gives the physical address 0x0300008A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_wr_i | input | 1 | Load the directory base register |
| base_i | input | 32 | New directory base (low 12 bits ignored) |
| req_valid_i | input | 1 | Start a walk (taken only when ready) |
| req_lin_i | input | 32 | Linear address to translate |
| req_write_i | input | 1 | Access is a write |
| req_user_i | input | 1 | Access is at user privilege |
| req_ready_o | output | 1 | Walker idle |
| mem_req_o | output | 1 | Memory request active |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Memory word address (byte units) |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Memory acknowledge, one cycle |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| done_o | output | 1 | Walk finished (one-cycle pulse) |
| fault_o | output | 1 | Walk ended in a page fault (valid with done) |
| frame_o | output | 20 | Physical frame number |
| attr_o | output | 3 | {dirty, user-allowed, writable} |
| fault_addr_o | output | 32 | Linear address of the last fault |

## Verification
Some rules are checked by the assertions on every cycle. These are: the memory handshake holds steady until it is acknowledged, a write-back goes to the address just read, and it differs from the value read only in the accessed and dirty bits. They also check that done lasts one cycle, that no memory traffic happens while the walker is idle, and that a successful walk keeps the fault address. Other behaviour can only be shown by the bench's scenarios, which compare against a reference walk computed in the bench. These are the index arithmetic, the choice between fault and success, the protection decisions, the exact counts of reads and writes, and the entry values left in memory.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
   localparam int unsigned BIT_P  = 0;
   localparam int unsigned BIT_RW = 1;
   localparam int unsigned BIT_US = 2;
   localparam int unsigned BIT_A  = 5;
   localparam int unsigned BIT_D  = 6;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DIR_RD,
      ST_DIR_WB,
      ST_TBL_RD,
      ST_TBL_WB
   } walk_st_e;
endpackage

// File: rtl/pgw_addr.sv
module pgw_addr #(
   parameter int unsigned AW    = 32,
   parameter int unsigned LVL_W = 10,
   parameter int unsigned OFS_W = 12,
   parameter int unsigned ENT_B = 4
) (
   input  logic [AW-1:0]       base_i,
   input  logic [LVL_W-1:0]    dir_idx_i,
   input  logic [AW-OFS_W-1:0] tbl_frm_i,
   input  logic [LVL_W-1:0]    tbl_idx_i,
   output logic [AW-1:0]       dir_addr_o,
   output logic [AW-1:0]       tbl_addr_o
);
   localparam int unsigned ENT_SH = $clog2(ENT_B);

   // the base is page aligned, so the sum never carries into the frame bits
   assign dir_addr_o = base_i + (AW'(dir_idx_i) << ENT_SH);
   assign tbl_addr_o = {tbl_frm_i, {OFS_W{1'b0}}} + (AW'(tbl_idx_i) << ENT_SH);
endmodule

// File: rtl/pgw_perm.sv
module pgw_perm #(
   parameter bit SUP_WP = 1'b0
) (
   input  logic dir_rw_i,
   input  logic dir_us_i,
   input  logic tbl_rw_i,
   input  logic tbl_us_i,
   input  logic wr_i,
   input  logic user_i,
   output logic eff_rw_o,
   output logic eff_us_o,
   output logic viol_o
);
   assign eff_rw_o = dir_rw_i & tbl_rw_i;
   assign eff_us_o = dir_us_i & tbl_us_i;

   generate
      if (SUP_WP) begin : g_sup_wp
         assign viol_o = (user_i & ~eff_us_o) | (wr_i & ~eff_rw_o);
      end else begin : g_sup_free
         assign viol_o = user_i & (~eff_us_o | (wr_i & ~eff_rw_o));
      end
   endgenerate
endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
   import pgw_pkg::*;
#(
   parameter int unsigned AW    = 32,
   parameter int unsigned LVL_W = 10,
   parameter int unsigned OFS_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid_i,
   input  logic [AW-1:0]       req_lin_i,
   input  logic                req_write_i,
   input  logic                req_user_i,
   output logic                req_ready_o,
   input  logic [AW-1:0]       dir_addr_i,
   input  logic [AW-1:0]       tbl_addr_i,
   output logic [AW-OFS_W-1:0] tbl_frm_o,
   output logic [LVL_W-1:0]    tbl_idx_o,
   output logic [AW-1:0]       pte_cur_o,
   output logic                wr_o,
   output logic                user_o,
   output logic                dir_rw_o,
   output logic                dir_us_o,
   input  logic                eff_rw_i,
   input  logic                eff_us_i,
   input  logic                viol_i,
   output logic                mem_req_o,
   output logic                mem_we_o,
   output logic [AW-1:0]       mem_addr_o,
   output logic [AW-1:0]       mem_wdata_o,
   input  logic                mem_ack_i,
   input  logic [AW-1:0]       mem_rdata_i,
   output logic                done_o,
   output logic                fault_o,
   output logic [AW-OFS_W-1:0] frame_o,
   output logic [2:0]          attr_o,
   output logic [AW-1:0]       fault_addr_o
);
   localparam logic [AW-1:0] A_MASK = AW'(1) << BIT_A;
   localparam logic [AW-1:0] D_MASK = AW'(1) << BIT_D;

   walk_st_e       st_q;
   logic [AW-1:0]  lin_q, dir_addr_q, pde_q, pte_q, pte_upd;
   logic           wr_q, user_q;

   assign req_ready_o = (st_q == ST_IDLE);
   assign tbl_frm_o   = pde_q[AW-1:OFS_W];
   assign tbl_idx_o   = lin_q[OFS_W+LVL_W-1:OFS_W];
   assign pte_cur_o   = (st_q == ST_TBL_RD) ? mem_rdata_i : pte_q;
   assign wr_o        = wr_q;
   assign user_o      = user_q;
   assign dir_rw_o    = pde_q[BIT_RW];
   assign dir_us_o    = pde_q[BIT_US];
   assign pte_upd     = mem_rdata_i | A_MASK | (wr_q ? D_MASK : '0);

   always_comb begin
      mem_req_o   = 1'b0;
      mem_we_o    = 1'b0;
      mem_addr_o  = dir_addr_q;
      mem_wdata_o = pde_q | A_MASK;
      unique case (st_q)
         ST_DIR_RD: mem_req_o = 1'b1;
         ST_DIR_WB: begin mem_req_o = 1'b1; mem_we_o = 1'b1; end
         ST_TBL_RD: begin mem_req_o = 1'b1; mem_addr_o = tbl_addr_i; end
         ST_TBL_WB: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = tbl_addr_i;
            mem_wdata_o = pte_q;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ST_IDLE;
         lin_q        <= '0;
         dir_addr_q   <= '0;
         pde_q        <= '0;
         pte_q        <= '0;
         wr_q         <= 1'b0;
         user_q       <= 1'b0;
         done_o       <= 1'b0;
         fault_o      <= 1'b0;
         frame_o      <= '0;
         attr_o       <= '0;
         fault_addr_o <= '0;
      end else begin
         done_o  <= 1'b0;
         fault_o <= 1'b0;
         case (st_q)
            ST_IDLE: if (req_valid_i) begin
               lin_q      <= req_lin_i;
               wr_q       <= req_write_i;
               user_q     <= req_user_i;
               dir_addr_q <= dir_addr_i;
               st_q       <= ST_DIR_RD;
            end
            ST_DIR_RD: if (mem_ack_i) begin
               pde_q <= mem_rdata_i;
               if (!mem_rdata_i[BIT_P]) begin
                  done_o       <= 1'b1;
                  fault_o      <= 1'b1;
                  fault_addr_o <= lin_q;
                  st_q         <= ST_IDLE;
               end else if (!mem_rdata_i[BIT_A]) begin
                  st_q <= ST_DIR_WB;
               end else begin
                  st_q <= ST_TBL_RD;
               end
            end
            ST_DIR_WB: if (mem_ack_i) st_q <= ST_TBL_RD;
            ST_TBL_RD: if (mem_ack_i) begin
               pte_q <= pte_upd;
               if (!mem_rdata_i[BIT_P] || viol_i) begin
                  done_o       <= 1'b1;
                  fault_o      <= 1'b1;
                  fault_addr_o <= lin_q;
                  st_q         <= ST_IDLE;
               end else if (pte_upd != mem_rdata_i) begin
                  st_q <= ST_TBL_WB;
               end else begin
                  done_o  <= 1'b1;
                  frame_o <= mem_rdata_i[AW-1:OFS_W];
                  attr_o  <= {mem_rdata_i[BIT_D], eff_us_i, eff_rw_i};
                  st_q    <= ST_IDLE;
               end
            end
            ST_TBL_WB: if (mem_ack_i) begin
               done_o  <= 1'b1;
               frame_o <= pte_q[AW-1:OFS_W];
               attr_o  <= {pte_q[BIT_D], eff_us_i, eff_rw_i};
               st_q    <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pgw_top.sv
module pgw_top
   import pgw_pkg::*;
#(
   parameter int unsigned AW     = 32,
   parameter int unsigned LVL_W  = 10,
   parameter int unsigned OFS_W  = 12,
   parameter bit          SUP_WP = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                base_wr_i,
   input  logic [AW-1:0]       base_i,
   input  logic                req_valid_i,
   input  logic [AW-1:0]       req_lin_i,
   input  logic                req_write_i,
   input  logic                req_user_i,
   output logic                req_ready_o,
   output logic                mem_req_o,
   output logic                mem_we_o,
   output logic [AW-1:0]       mem_addr_o,
   output logic [AW-1:0]       mem_wdata_o,
   input  logic                mem_ack_i,
   input  logic [AW-1:0]       mem_rdata_i,
   output logic                done_o,
   output logic                fault_o,
   output logic [AW-OFS_W-1:0] frame_o,
   output logic [2:0]          attr_o,
   output logic [AW-1:0]       fault_addr_o
);
   localparam int unsigned   FRM_W   = AW - OFS_W;
   localparam int unsigned   ENT_B   = AW / 8;
   localparam logic [AW-1:0] PG_MASK = ~AW'((64'd1 << OFS_W) - 64'd1);

   generate
      if (AW != 2 * LVL_W + OFS_W) begin : g_bad_split
         $error("pgw_top: two index fields plus the offset must fill the address");
      end
      if ((1 << LVL_W) * ENT_B != (1 << OFS_W)) begin : g_bad_table
         $error("pgw_top: one table must fill exactly one page");
      end
      if (OFS_W <= BIT_D) begin : g_bad_ofs
         $error("pgw_top: status bits must sit below the frame field");
      end
   endgenerate

   logic [AW-1:0]    base_q;
   logic [AW-1:0]    dir_addr, tbl_addr, pte_cur;
   logic [FRM_W-1:0] tbl_frm;
   logic [LVL_W-1:0] tbl_idx;
   logic             wr, user, dir_rw, dir_us, eff_rw, eff_us, viol;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         base_q <= '0;
      else if (base_wr_i) base_q <= base_i & PG_MASK;
   end

   pgw_addr #(.AW(AW), .LVL_W(LVL_W), .OFS_W(OFS_W), .ENT_B(ENT_B)) u_addr (
      .base_i     (base_q),
      .dir_idx_i  (req_lin_i[AW-1 -: LVL_W]),
      .tbl_frm_i  (tbl_frm),
      .tbl_idx_i  (tbl_idx),
      .dir_addr_o (dir_addr),
      .tbl_addr_o (tbl_addr)
   );

   pgw_perm #(.SUP_WP(SUP_WP)) u_perm (
      .dir_rw_i (dir_rw),
      .dir_us_i (dir_us),
      .tbl_rw_i (pte_cur[BIT_RW]),
      .tbl_us_i (pte_cur[BIT_US]),
      .wr_i     (wr),
      .user_i   (user),
      .eff_rw_o (eff_rw),
      .eff_us_o (eff_us),
      .viol_o   (viol)
   );

   pgw_ctrl #(.AW(AW), .LVL_W(LVL_W), .OFS_W(OFS_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid_i  (req_valid_i),
      .req_lin_i    (req_lin_i),
      .req_write_i  (req_write_i),
      .req_user_i   (req_user_i),
      .req_ready_o  (req_ready_o),
      .dir_addr_i   (dir_addr),
      .tbl_addr_i   (tbl_addr),
      .tbl_frm_o    (tbl_frm),
      .tbl_idx_o    (tbl_idx),
      .pte_cur_o    (pte_cur),
      .wr_o         (wr),
      .user_o       (user),
      .dir_rw_o     (dir_rw),
      .dir_us_o     (dir_us),
      .eff_rw_i     (eff_rw),
      .eff_us_i     (eff_us),
      .viol_i       (viol),
      .mem_req_o    (mem_req_o),
      .mem_we_o     (mem_we_o),
      .mem_addr_o   (mem_addr_o),
      .mem_wdata_o  (mem_wdata_o),
      .mem_ack_i    (mem_ack_i),
      .mem_rdata_i  (mem_rdata_i),
      .done_o       (done_o),
      .fault_o      (fault_o),
      .frame_o      (frame_o),
      .attr_o       (attr_o),
      .fault_addr_o (fault_addr_o)
   );
endmodule

// File: rtl/pgw_sva.sv
module pgw_sva
   import pgw_pkg::*;
#(
   parameter int unsigned AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_ready_o,
   input logic          mem_req_o,
   input logic          mem_we_o,
   input logic [AW-1:0] mem_addr_o,
   input logic [AW-1:0] mem_wdata_o,
   input logic          mem_ack_i,
   input logic [AW-1:0] mem_rdata_i,
   input logic          done_o,
   input logic          fault_o,
   input logic [AW-1:0] fault_addr_o
);
   localparam logic [AW-1:0] ST_BITS = (AW'(1) << BIT_A) | (AW'(1) << BIT_D);

   logic [AW-1:0] last_rd, last_ra;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_rd <= '0;
         last_ra <= '0;
      end else if (mem_req_o && !mem_we_o && mem_ack_i) begin
         last_rd <= mem_rdata_i;
         last_ra <= mem_addr_o;
      end
   end

   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> !req_ready_o);
   a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                     && $stable(mem_we_o) && $stable(mem_wdata_o)));
   a_r8_wb_status_only: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_we_o) |-> (((mem_wdata_o ^ last_rd) & ~ST_BITS) == '0));
   a_r7_wb_sets_a: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_we_o) |-> (mem_wdata_o[BIT_A] && mem_wdata_o != last_rd));
   a_r8_wb_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_we_o) |-> (mem_addr_o == last_ra));
   a_r10_fa_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !fault_o) |-> $stable(fault_addr_o));
endmodule

bind pgw_top pgw_sva #(.AW(AW)) u_sva (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_ready_o  (req_ready_o),
   .mem_req_o    (mem_req_o),
   .mem_we_o     (mem_we_o),
   .mem_addr_o   (mem_addr_o),
   .mem_wdata_o  (mem_wdata_o),
   .mem_ack_i    (mem_ack_i),
   .mem_rdata_i  (mem_rdata_i),
   .done_o       (done_o),
   .fault_o      (fault_o),
   .fault_addr_o (fault_addr_o)
);

// File: tb/tb_pgw_top.sv
`timescale 1ns/1ps
module tb_pgw_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        base_wr_i = 1'b0;
   logic [31:0] base_i = '0;
   logic        req_valid_i = 1'b0;
   logic [31:0] req_lin_i = '0;
   logic        req_write_i = 1'b0;
   logic        req_user_i = 1'b0;
   logic        req_ready_o, mem_req_o, mem_we_o, done_o, fault_o;
   logic [31:0] mem_addr_o, mem_wdata_o, fault_addr_o;
   logic        mem_ack_i = 1'b0;
   logic [31:0] mem_rdata_i = '0;
   logic [19:0] frame_o;
   logic [2:0]  attr_o;

   always #2.5 clk = ~clk;

   pgw_top dut (.*);

   int unsigned n_chk = 0, n_fail = 0;
   bit          finished = 1'b0;
   logic [31:0] mem [logic [31:0]];
   logic [31:0] rd_addr [4];
   int          n_rd = 0, n_wr = 0, lat = 0;
   logic [31:0] cur_base = '0, exp_fa = '0;

   function automatic logic [31:0] peek(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   // memory model: answers one request at a time after a short random delay
   always @(negedge clk) begin
      if (mem_ack_i) begin
         mem_ack_i = 1'b0;
      end else if (mem_req_o) begin
         if (lat > 0) lat--;
         else begin
            mem_ack_i = 1'b1;
            if (mem_we_o) begin
               mem[mem_addr_o] = mem_wdata_o;
               n_wr++;
            end else begin
               mem_rdata_i = peek(mem_addr_o);
               if (n_rd < 4) rd_addr[n_rd] = mem_addr_o;
               n_rd++;
            end
            lat = $urandom % 3;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   task automatic set_base(input logic [31:0] b);
      @(negedge clk);
      base_wr_i = 1'b1; base_i = b;
      @(negedge clk);
      base_wr_i = 1'b0;
      cur_base = b & 32'hFFFF_F000;
   endtask

   task automatic walk(input logic [31:0] lin, input logic wr, input logic usr,
                       input logic [31:0] pde, input logic [31:0] pte, input bit spam);
      logic [31:0] pa, ta, pde_f, pte_f;
      logic        e_fault, viol, eus, erw;
      int          e_rd, e_wr, cnt;
      pa = cur_base + {20'h0, lin[31:22], 2'b00};
      ta = {pde[31:12], 12'h0} + {20'h0, lin[21:12], 2'b00};
      mem.delete();
      mem[pa] = pde;
      if (pde[0]) mem[ta] = pte;
      // reference walk
      pde_f = pde; pte_f = pte; e_wr = 0; e_rd = 1;
      eus = pde[2] & pte[2]; erw = pde[1] & pte[1];
      viol = usr && (!eus || (wr && !erw));
      if (!pde[0]) e_fault = 1'b1;
      else begin
         if (!pde[5]) begin pde_f = pde | 32'h20; e_wr++; end
         e_rd = 2;
         if (!pte[0] || viol) e_fault = 1'b1;
         else begin
            e_fault = 1'b0;
            pte_f = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
            if (pte_f != pte) e_wr++;
         end
      end
      n_rd = 0; n_wr = 0;
      @(negedge clk);
      req_valid_i = 1'b1; req_lin_i = lin; req_write_i = wr; req_user_i = usr;
      @(negedge clk);
      if (spam) begin
         chk("R11 ready low while busy", {31'h0, req_ready_o}, 32'h0);
         req_lin_i = ~lin; req_write_i = ~wr; req_user_i = ~usr;
         @(negedge clk);
      end
      req_valid_i = 1'b0;
      cnt = 0;
      while (!done_o && cnt < 300) begin @(negedge clk); cnt++; end
      chk("R11 done seen", {31'h0, done_o}, 32'h1);
      chk("R2 directory read address", rd_addr[0], pa);
      chk("R5/R6/R9 fault flag", {31'h0, fault_o}, {31'h0, e_fault});
      chk("R5 read count", n_rd, e_rd);
      if (e_rd == 2) chk("R3 table read address", rd_addr[1], ta);
      chk("R7/R8 write count", n_wr, e_wr);
      chk("R7 directory entry in memory", peek(pa), pde_f);
      if (pde[0]) chk("R6/R8/R9 table entry in memory", peek(ta), pte_f);
      if (e_fault) exp_fa = lin;
      chk("R10 fault address", fault_addr_o, exp_fa);
      if (!e_fault) begin
         chk("R4 frame", {12'h0, frame_o}, {12'h0, pte[31:12]});
         chk("R4 attributes", {29'h0, attr_o}, {29'h0, pte_f[6], eus, erw});
      end
      @(negedge clk);
      chk("R11 done is one cycle", {31'h0, done_o}, 32'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 done", {31'h0, done_o}, 32'h0);
      chk("R1 fault", {31'h0, fault_o}, 32'h0);
      chk("R1 mem_req", {31'h0, mem_req_o}, 32'h0);
      chk("R1 ready", {31'h0, req_ready_o}, 32'h1);
      chk("R1 fault address", fault_addr_o, 32'h0);
      rst_n = 1'b1;
      // R12 worked example, with junk low base bits (R2)
      set_base(32'h0001_0ABC);
      walk(32'h0301_008A, 1'b0, 1'b0, 32'h0500_1027, 32'h0300_0027, 1'b0);
      chk("R12 directory fetch", rd_addr[0], 32'h0001_0030);
      chk("R12 table fetch", rd_addr[1], 32'h0500_1040);
      chk("R12 physical address", {frame_o, 12'h08A}, 32'h0300_008A);
      // directed corners
      walk(32'h0301_008A, 1'b1, 1'b0, 32'h0500_1003, 32'h0300_0001, 1'b1); // R7 R8 both set, supervisor write to read-only
      walk(32'h1234_5678, 1'b0, 1'b0, 32'h0700_0066, 32'h0800_0001, 1'b0); // R5 not-present directory
      walk(32'h1234_5678, 1'b1, 1'b0, 32'h0700_0021, 32'h0800_0000, 1'b0); // R6 not-present table
      walk(32'hFFFF_FFFF, 1'b0, 1'b1, 32'h0700_0025, 32'h0800_0003, 1'b1); // R9 user, table not user
      walk(32'h0040_1000, 1'b1, 1'b1, 32'h0700_0025, 32'h0800_0067, 1'b0); // R9 user write, dir read-only
      walk(32'h0040_1000, 1'b1, 1'b1, 32'h0700_0027, 32'h0800_0067, 1'b0); // R8 no change, no write
      // random walks, base changed now and then
      for (int i = 0; i < 400; i++) begin
         logic [31:0] pde, pte;
         if (i % 37 == 0) set_base($urandom);
         pde = $urandom; pte = $urandom;
         pde[0] = ($urandom % 100) < 85;
         pte[0] = ($urandom % 100) < 85;
         while (pde[31:12] == cur_base[31:12]) pde[31:12] = $urandom;
         walk($urandom, 1'($urandom), 1'($urandom), pde, pte, ($urandom % 8) == 0);
      end
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule